// File: doc/BRIEF.md
# Multi-Slot Interrupt Aggregator with Acknowledge

This block gathers the interrupt request lines of four module slots, two lines per slot, into a single host interrupt. Each slot has an 8-bit control register. One bit per line enables that line. A second bit per line chooses edge or level sensitivity. A status register holds the pending bit of every line and a timeout flag per slot. Host software clears entries by writing ones to the status register. It can also acknowledge a level-sensitive line by reading that slot's interrupt space, which the block receives as an acknowledge strobe.

Both kinds of source share one host output. A level-sensitive pending line holds the output high until the line is cleared. An edge-sensitive line that rises inverts the output for exactly one cycle. Every clear the block applies to a line also goes out as a one-cycle pulse on `mod_clr`, so the module in that slot can drop its request. A register port at halfword offsets exposes the control and status registers.

Top module: `irqagg_top`

## Requirements
- R1: After reset, all control registers, all pending bits, all timeout flags, `host_irq`, `mod_clr` and `reg_rdata` are 0.
- R2: Source index i = slot*2 + line. A change of `req_in[i]` sampled at a clock edge loads the new level into pending bit i at that edge, but only if control bit 6+line of that slot is 1. When that bit is 0 the change is ignored and the status register is unchanged.
- R3: `host_irq` is registered. One cycle after any pending bit whose edge bit (control bit 4+line) is 0 is set, `host_irq` is 1. One cycle after no such bit remains, `host_irq` is 0. The enable bit plays no part in this.
- R4: Suppose an enabled line with edge bit 1 rises while its pending bit is 0. Then `host_irq` is inverted for exactly one cycle, starting two edges after the rise is sampled.
- R5: Register offsets on `reg_addr`: 0x00 is the revision register, which reads 0 and ignores writes. 0x02, 0x04, 0x06 and 0x08 are the control registers of slots 0 to 3, read and write in bits 7:0. 0x0A reads 0 and writes to it have no effect. 0x0C is status. Any other offset reads 0. `reg_rdata` appears one cycle after the access and is 0 in cycles with no read.
- R6: An access at an odd `reg_addr` is ignored: it writes nothing and reads 0.
- R7: A pulse on `tmo_evt[s]` sets status bit 12+s. Writing 1 to status bit 12+s clears it. A set and a clear in the same cycle leave the bit set.
- R8: Writing 1 to status bit i (i < 8) clears pending bit i and pulses `mod_clr[i]` for one cycle after the write edge. Status bits 8 to 11 always read 0, and writes to them have no effect.
- R9: An `ack_valid` strobe with `ack_off` 0 acknowledges line 0 of `ack_slot`, and `ack_off` 2 acknowledges line 1. The acknowledge clears the pending bit, and pulses `mod_clr` the next cycle, only if that bit is pending and level-sensitive. Any other offset, or an edge-sensitive line, is left alone.
- R10: If a clear and an enabled request change hit the same line in the same cycle, the request level wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 8 | Request levels, index slot*2+line |
| tmo_evt | input | 4 | Per-slot timeout event pulses |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the halfword register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after the access |
| ack_valid | input | 1 | Interrupt-space read strobe |
| ack_slot | input | 2 | Slot of the interrupt-space read |
| ack_off | input | 6 | Offset within the interrupt space |
| mod_clr | output | 8 | One-cycle clear pulse to each source |
| host_irq | output | 1 | Merged host interrupt |

## Verification
The checker assumes the request levels, timeout pulses and strobes are synchronous to `clk` and stable around the edge. It also assumes a pending bit changes only through a sampled request change or a clear. With those assumptions, the hold and pulse properties can look one edge back.

The bench drives every input half a cycle away from the edge. Its random traffic draws halfword offsets across the whole map, with odd offsets mixed in on purpose. It toggles request bits freely, so enable and edge settings change while lines are pending. It sends acknowledges at both valid offsets and at invalid ones.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned SLOTS    = 4;
  localparam int unsigned LINES    = 2;
  localparam int unsigned SRCS     = SLOTS * LINES;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned AOFS_W   = 6;
  localparam int unsigned TMO_LSB  = 12;
  localparam int unsigned EDGE_LSB = 4;
  localparam int unsigned EN_LSB   = 6;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h0C;

  typedef logic [SLOTS-1:0][CTRL_W-1:0] ctrl_bank_t;

  // flat index of a slot's line in pending and clear vectors
  function automatic int unsigned src_idx(int unsigned slot, int unsigned line);
    return slot * LINES + line;
  endfunction

  // byte offset of a slot's control register
  function automatic logic [ADDR_W-1:0] ctl_ofs(int unsigned slot);
    return ADDR_W'((slot + 1) * 2);
  endfunction

  // gather one per-line control field of every slot into a source vector
  function automatic logic [SRCS-1:0] field_mask(ctrl_bank_t b, int unsigned lsb);
    logic [SRCS-1:0] m;
    m = '0;
    for (int unsigned s = 0; s < SLOTS; s++)
      for (int unsigned l = 0; l < LINES; l++)
        m[src_idx(s, l)] = b[s][lsb + l];
    return m;
  endfunction

  // status word: pending low, timeout flags high, error field always zero
  function automatic logic [REG_W-1:0] status_word(logic [SRCS-1:0] p, logic [SLOTS-1:0] t);
    logic [REG_W-1:0] w;
    w = '0;
    w[SRCS-1:0] = p;
    w[TMO_LSB +: SLOTS] = t;
    return w;
  endfunction
endpackage

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_sel,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  input  logic [SRCS-1:0]       pend_q,
  input  logic [SLOTS-1:0]      tmo_q,
  output ctrl_bank_t            ctrl_q,
  output logic [SRCS-1:0]       wr_clr_src,
  output logic [SLOTS-1:0]      wr_clr_tmo,
  output logic [REG_W-1:0]      reg_rdata
);
  logic acc_ok, wr_ok, rd_ok, stat_hit;
  logic [REG_W-1:0] rd_mux;

  assign acc_ok   = reg_sel && !reg_addr[0];
  assign wr_ok    = acc_ok && reg_we;
  assign rd_ok    = acc_ok && !reg_we;
  assign stat_hit = wr_ok && (reg_addr == OFS_STAT);

  assign wr_clr_src = stat_hit ? reg_wdata[SRCS-1:0] : '0;
  assign wr_clr_tmo = stat_hit ? reg_wdata[TMO_LSB +: SLOTS] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      for (int unsigned s = 0; s < SLOTS; s++)
        if (wr_ok && reg_addr == ctl_ofs(s))
          ctrl_q[s] <= reg_wdata[CTRL_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == OFS_STAT)
      rd_mux = status_word(pend_q, tmo_q);
    for (int unsigned s = 0; s < SLOTS; s++)
      if (reg_addr == ctl_ofs(s))
        rd_mux = {{(REG_W-CTRL_W){1'b0}}, ctrl_q[s]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_ok ? rd_mux : '0;
  end
endmodule

// File: rtl/irqagg_pending.sv
module irqagg_pending
  import irqagg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SRCS-1:0]       req_in,
  input  logic [SRCS-1:0]       en_mask,
  input  logic [SRCS-1:0]       edge_mask,
  input  logic [SRCS-1:0]       wr_clr_src,
  input  logic [SLOTS-1:0]      wr_clr_tmo,
  input  logic [SLOTS-1:0]      tmo_evt,
  input  logic                  ack_valid,
  input  logic [$clog2(SLOTS)-1:0] ack_slot,
  input  logic [AOFS_W-1:0]     ack_off,
  output logic [SRCS-1:0]       pend_q,
  output logic [SLOTS-1:0]      tmo_q,
  output logic [SRCS-1:0]       src_clr,
  output logic                  fire_q,
  output logic [SRCS-1:0]       mod_clr
);
  logic [SRCS-1:0] req_q, evt, ack_sel, ack_clr, pend_d;
  logic fire_d;

  // acknowledge decode: one select per source
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    for (genvar l = 0; l < LINES; l++) begin : g_line
      assign ack_sel[s*LINES+l] = ack_valid && (ack_slot == s)
                                  && (ack_off == AOFS_W'(l*2));
    end
  end

  assign evt     = (req_in ^ req_q) & en_mask;
  assign ack_clr = ack_sel & pend_q & ~edge_mask;
  assign src_clr = wr_clr_src | ack_clr;
  // clear first, sampled request change last so it wins
  assign pend_d  = ((pend_q & ~src_clr) & ~evt) | (req_in & evt);
  assign fire_d  = |(evt & req_in & ~pend_q & edge_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= '0;
      pend_q  <= '0;
      tmo_q   <= '0;
      fire_q  <= 1'b0;
      mod_clr <= '0;
    end else begin
      req_q   <= req_in;
      pend_q  <= pend_d;
      tmo_q   <= (tmo_q & ~wr_clr_tmo) | tmo_evt;
      fire_q  <= fire_d;
      mod_clr <= src_clr;
    end
  end
endmodule

// File: rtl/irqagg_host.sv
module irqagg_host
  import irqagg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRCS-1:0]   pend_q,
  input  logic [SRCS-1:0]   edge_mask,
  input  logic              fire_q,
  output logic              lvl_any,
  output logic              host_irq
);
  assign lvl_any = |(pend_q & ~edge_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) host_irq <= 1'b0;
    else        host_irq <= lvl_any ^ fire_q;
  end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SRCS-1:0]          req_in,
  input  logic [SLOTS-1:0]         tmo_evt,
  input  logic                     reg_sel,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  input  logic                     ack_valid,
  input  logic [$clog2(SLOTS)-1:0] ack_slot,
  input  logic [AOFS_W-1:0]        ack_off,
  output logic [SRCS-1:0]          mod_clr,
  output logic                     host_irq
);
  ctrl_bank_t      ctrl_q;
  logic [SRCS-1:0] en_mask, edge_mask, pend_q, src_clr, wr_clr_src;
  logic [SLOTS-1:0] tmo_q, wr_clr_tmo;
  logic fire_q, lvl_any;

  assign en_mask   = field_mask(ctrl_q, EN_LSB);
  assign edge_mask = field_mask(ctrl_q, EDGE_LSB);

  irqagg_regs u_regs (
    .clk, .rst_n, .reg_sel, .reg_we, .reg_addr, .reg_wdata,
    .pend_q, .tmo_q, .ctrl_q, .wr_clr_src, .wr_clr_tmo, .reg_rdata
  );

  irqagg_pending u_pend (
    .clk, .rst_n, .req_in, .en_mask, .edge_mask, .wr_clr_src, .wr_clr_tmo,
    .tmo_evt, .ack_valid, .ack_slot, .ack_off,
    .pend_q, .tmo_q, .src_clr, .fire_q, .mod_clr
  );

  irqagg_host u_host (
    .clk, .rst_n, .pend_q, .edge_mask, .fire_q, .lvl_any, .host_irq
  );
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
  import irqagg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [SLOTS-1:0]  tmo_evt,
  input logic              reg_sel,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [SRCS-1:0]   mod_clr,
  input logic              host_irq,
  input logic [SRCS-1:0]   pend_q,
  input logic [SLOTS-1:0]  tmo_q,
  input logic [SRCS-1:0]   en_mask,
  input logic [SRCS-1:0]   src_clr,
  input logic              lvl_any,
  input logic              fire_q
);
  for (genvar i = 0; i < SRCS; i++) begin : g_src
    // R2
    dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_mask[i] && !src_clr[i]) |=> $stable(pend_q[i]));
    // R8
    stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel && reg_we && reg_addr == OFS_STAT && reg_wdata[i]) |=> mod_clr[i]);
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_tmo
    // R7
    tmo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_evt[s] |=> tmo_q[s]);
  end

  // R3
  lvl_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_any && !fire_q) |=> host_irq);
  // R3
  lvl_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_any && !fire_q) |=> !host_irq);
  // R4
  pulse_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> (host_irq != $past(lvl_any)));
  // R5
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_sel && !reg_we) |=> (reg_rdata == '0));
  // R6
  odd_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_addr[0]) |=> (reg_rdata == '0));
endmodule

bind irqagg_top irqagg_chk u_chk (.*);

// File: tb/irqagg_top_bench.sv
module irqagg_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  req_in = '0;
  logic [3:0]  tmo_evt = '0;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ack_valid = 1'b0;
  logic [1:0]  ack_slot = '0;
  logic [5:0]  ack_off = '0;
  logic [7:0]  mod_clr;
  logic        host_irq;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model state
  logic [7:0] m_ctrl [4];
  logic [7:0] m_pend = '0, m_reqp = '0, m_clr = '0;
  logic [3:0] m_tmo = '0;
  logic       m_fire = 1'b0, m_host = 1'b0;
  logic [15:0] m_rd = '0;

  always #2 clk = ~clk;

  irqagg_top u_irqagg_top (
    .clk, .rst_n, .req_in, .tmo_evt, .reg_sel, .reg_we, .reg_addr,
    .reg_wdata, .reg_rdata, .ack_valid, .ack_slot, .ack_off, .mod_clr, .host_irq
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [7:0] a);
    if (a[0]) return 16'h0;
    if (a == 8'h0C) return {m_tmo, 4'h0, m_pend};
    if (a >= 8'h02 && a <= 8'h08) return {8'h00, m_ctrl[a/2-1]};
    return 16'h0;
  endfunction

  // one clock: predict, advance, compare, release strobes
  task automatic tick();
    logic [7:0] en, edg, evt, clr, n_pend;
    logic [3:0] n_tmo;
    logic n_fire, n_host;
    logic [15:0] n_rd;
    bit st_wr;
    for (int s = 0; s < 4; s++)
      for (int l = 0; l < 2; l++) begin
        en[s*2+l]  = m_ctrl[s][6+l];
        edg[s*2+l] = m_ctrl[s][4+l];
      end
    evt = (req_in ^ m_reqp) & en;
    st_wr = reg_sel && reg_we && !reg_addr[0] && reg_addr == 8'h0C;
    clr = st_wr ? reg_wdata[7:0] : 8'h00;
    if (ack_valid && (ack_off == 6'd0 || ack_off == 6'd2)) begin
      int idx = int'(ack_slot) * 2 + ((ack_off == 6'd2) ? 1 : 0);
      if (m_pend[idx] && !edg[idx]) clr[idx] = 1'b1;
    end
    n_pend = ((m_pend & ~clr) & ~evt) | (req_in & evt);
    n_fire = |(evt & req_in & ~m_pend & edg);
    n_host = (|(m_pend & ~edg)) ^ m_fire;
    n_tmo  = (m_tmo & ~(st_wr ? reg_wdata[15:12] : 4'h0)) | tmo_evt;
    n_rd   = (reg_sel && !reg_we) ? m_read(reg_addr) : 16'h0;
    @(posedge clk);
    @(negedge clk);
    if (reg_sel && reg_we && !reg_addr[0] && reg_addr >= 8'h02 && reg_addr <= 8'h08)
      m_ctrl[reg_addr/2-1] = reg_wdata[7:0];
    m_pend = n_pend; m_fire = n_fire; m_host = n_host; m_tmo = n_tmo;
    m_clr = clr; m_rd = n_rd; m_reqp = req_in;
    chk(host_irq == m_host, "R3/R4 host", {15'h0, host_irq}, {15'h0, m_host});
    chk(mod_clr == m_clr, "R8/R9 clear", {8'h0, mod_clr}, {8'h0, m_clr});
    chk(reg_rdata == m_rd, "R5 read", reg_rdata, m_rd);
    reg_sel = 1'b0; reg_we = 1'b0; ack_valid = 1'b0; tmo_evt = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
    tick();
    v = reg_rdata;
  endtask

  task automatic ack(input logic [1:0] s, input logic [5:0] o);
    ack_valid = 1'b1; ack_slot = s; ack_off = o;
    tick();
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4242));
    for (int s = 0; s < 4; s++) m_ctrl[s] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(host_irq == 1'b0, "R1 host", {15'h0, host_irq}, 16'h0);
    chk(mod_clr == 8'h0, "R1 mod_clr", {8'h0, mod_clr}, 16'h0);
    rd(8'h0C, v); chk(v == 16'h0, "R1 status", v, 16'h0);
    rd(8'h04, v); chk(v == 16'h0, "R1 ctrl", v, 16'h0);
    // R5 control readback; slot 1 line 0 enabled, level
    wr(8'h04, 16'hAB40); rd(8'h04, v); chk(v == 16'h0040, "R5 ctrl rb", v, 16'h0040);
    // R2 / R3 level request
    req_in[2] = 1'b1; tick(); tick();
    chk(host_irq == 1'b1, "R3 level high", {15'h0, host_irq}, 16'h1);
    rd(8'h0C, v); chk(v == 16'h0004, "R2 pending", v, 16'h0004);
    // R2 disabled line ignored
    req_in[3] = 1'b1; tick();
    rd(8'h0C, v); chk(v == 16'h0004, "R2 disabled", v, 16'h0004);
    // R9 acknowledge level line
    ack(2'd1, 6'd0);
    chk(mod_clr == 8'h04, "R9 ack pulse", {8'h0, mod_clr}, 16'h0004);
    tick();
    chk(host_irq == 1'b0, "R3 level low", {15'h0, host_irq}, 16'h0);
    rd(8'h0C, v); chk(v == 16'h0, "R9 ack cleared", v, 16'h0);
    // R4 edge pulse on slot 0 line 0
    wr(8'h02, 16'h0050);
    req_in[0] = 1'b1; tick();
    tick(); chk(host_irq == 1'b1, "R4 pulse", {15'h0, host_irq}, 16'h1);
    tick(); chk(host_irq == 1'b0, "R4 pulse end", {15'h0, host_irq}, 16'h0);
    rd(8'h0C, v); chk(v == 16'h0001, "R4 status", v, 16'h0001);
    // R9 edge line not acknowledged
    ack(2'd0, 6'd0);
    chk(mod_clr == 8'h00, "R9 edge no pulse", {8'h0, mod_clr}, 16'h0);
    rd(8'h0C, v); chk(v == 16'h0001, "R9 edge kept", v, 16'h0001);
    // R8 write-one clear
    wr(8'h0C, 16'h0001);
    chk(mod_clr == 8'h01, "R8 clear pulse", {8'h0, mod_clr}, 16'h0001);
    rd(8'h0C, v); chk(v == 16'h0, "R8 cleared", v, 16'h0);
    // R7 timeout flags
    tmo_evt = 4'b0100; tick();
    rd(8'h0C, v); chk(v == 16'h4000, "R7 set", v, 16'h4000);
    wr(8'h0C, 16'h4F00); rd(8'h0C, v); chk(v == 16'h0, "R7/R8 clear, error bits", v, 16'h0);
    tmo_evt = 4'b0100; reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 8'h0C; reg_wdata = 16'h4000; tick();
    rd(8'h0C, v); chk(v == 16'h4000, "R7 set wins", v, 16'h4000);
    wr(8'h0C, 16'hF000);
    // R5 revision and reset registers
    wr(8'h00, 16'hFFFF); rd(8'h00, v); chk(v == 16'h0, "R5 revision", v, 16'h0);
    wr(8'h0A, 16'hFFFF); rd(8'h0A, v); chk(v == 16'h0, "R5 reset reg", v, 16'h0);
    rd(8'h02, v); chk(v == 16'h0050, "R5 reset no effect", v, 16'h0050);
    // R6 odd address
    wr(8'h03, 16'h00FF); rd(8'h02, v); chk(v == 16'h0050, "R6 odd write", v, 16'h0050);
    rd(8'h03, v); chk(v == 16'h0, "R6 odd read", v, 16'h0);
    // R10 request beats clear
    req_in[2] = 1'b0; tick();
    req_in[2] = 1'b1; reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 8'h0C; reg_wdata = 16'h0004; tick();
    rd(8'h0C, v); chk(v == 16'h0004, "R10 request wins", v, 16'h0004);
    // random traffic against the bench model
    for (int n = 0; n < 4000; n++) begin
      int op;
      if ($urandom % 3 == 0) req_in[$urandom % 8] = ~req_in[$urandom % 8];
      if ($urandom % 16 == 0) tmo_evt = 4'($urandom);
      op = int'($urandom % 10);
      if (op < 3) begin
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 8'(2 * (1 + $urandom % 4)); reg_wdata = 16'($urandom);
      end else if (op == 3) begin
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 8'h0C; reg_wdata = 16'($urandom);
      end else if (op < 7) begin
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = 8'(2 * ($urandom % 8));
      end else if (op == 7) begin
        reg_sel = 1'b1; reg_we = 1'($urandom); reg_addr = 8'(2 * ($urandom % 8) + 1); reg_wdata = 16'($urandom);
      end
      if ($urandom % 4 == 0) begin
        ack_valid = 1'b1; ack_slot = 2'($urandom);
        ack_off = ($urandom % 4 == 0) ? 6'($urandom) : 6'(2 * ($urandom % 2));
      end
      tick();
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule